// File: doc/BRIEF.md
# Display RAM Host Read-Latch Port

This block is the host-facing access port of a 16-bit-wide graphics RAM inside a display controller. Each bus cycle is decoded from a register-select line and a read/write line. A cycle can load the address register, write a data word, or read a data word. Reads pass through a one-word read latch. The first read after the address is loaded, or after any write, is a dummy read. It moves the addressed word into the latch and leaves the address where it is. Later reads put the latched word on the bus, step the address, and refill the latch from the new address. Back-to-back reads therefore stream consecutive words.

After each data read or write, the address counter steps by one (horizontal) or by a row stride (vertical). It counts up or down and wraps around the RAM size. A write can pass the bus word straight through. It can also combine the bus word with the latched word by AND, OR or XOR. This gives a read-modify-write that needs only one dummy read and then one write to the same address. The bus output is a plain data vector with an output-enable, and the enable is high only during read cycles.

Top module: `gram_host_port`

## Requirements
- R1: After reset the address is 0, the latch is marked not valid, `dout_oe` is 0 and `dout` is 0, so the first read after reset is a dummy read of word 0.
- R2: `dout_oe` is 1 only in a cycle with `cyc_valid`=1, `rs`=1 and `rw`=1. In every other cycle, `dout` is all zeros.
- R3: An address-set cycle (`rs`=0, `rw`=0) loads `din[AW-1:0]` into the address and marks the latch not valid, so the next read is a dummy.
- R4: A read while the latch is not valid is a dummy read. It loads the word at the current address into the latch, marks the latch valid and leaves the address unchanged.
- R5: A read while the latch is valid drives the latched word, which is the word at the current address, on `dout`. It then steps the address and reloads the latch from the new address.
- R6: The address step depends on `am` and `inc`. `am`=2'b00 steps by 1, `am`=2'b01 steps by STRIDE (32), and `am`=2'b10 or 2'b11 holds the address. `inc`=1 adds the step and `inc`=0 subtracts it.
- R7: A write cycle (`rs`=1, `rw`=0) with `lop`=2'b00 stores `din` at the current address, steps the address and marks the latch not valid.
- R8: A write with `lop`=2'b01, 2'b10 or 2'b11 stores `din` AND, OR or XOR the latched word, respectively.
- R9: A read-modify-write needs only an address set, one dummy read and one combining write. The result lands at the address that was set.
- R10: Cycles with `cyc_valid`=0, and cycles with `rs`=0 and `rw`=1, change neither the address nor the latch.
- R11: Address steps wrap modulo DEPTH (1024) in both directions and on both axes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| rs | input | 1 | Register select: 1 = data RAM, 0 = address register |
| rw | input | 1 | 1 = read, 0 = write |
| din | input | 16 | Bus write data / address value |
| inc | input | 1 | Step direction: 1 = up, 0 = down |
| am | input | 2 | Address step mode |
| lop | input | 2 | Write combine mode |
| dout | output | 16 | Read data |
| dout_oe | output | 1 | Read data enable |

## Verification
The RAM is first filled with a pattern in which every address holds a distinct value. This way any off-by-one address or stale latch shows up as a wrong word. The read streams cover both directions on both axes, and both hold encodings. They also start at addresses near 0 and near 1023, so that wrap in each direction is told apart from saturation. Directed sequences check three things: a new address set forces a fresh dummy read, a write invalidates the latch, and ignored cycle types leave the stream position untouched. Each combine mode is applied to a known word, so that AND, OR and XOR give results distinct from each other and from pass-through.

// File: rtl/gram_pkg.sv
package gram_pkg;
  typedef enum logic [1:0] {
    LOP_PASS = 2'b00,
    LOP_AND  = 2'b01,
    LOP_OR   = 2'b10,
    LOP_XOR  = 2'b11
  } lop_e;

  typedef enum logic [1:0] {
    AM_HORZ  = 2'b00,
    AM_VERT  = 2'b01,
    AM_HOLDA = 2'b10,
    AM_HOLDB = 2'b11
  } amode_e;
endpackage

// File: rtl/gram_addr_ctr.sv
module gram_addr_ctr #(
  parameter int DEPTH  = 1024,
  parameter int STRIDE = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc,
  input  logic [1:0]    am,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] addr_nxt
);
  import gram_pkg::*;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic up,
                                              input logic [1:0] mode);
    logic [AW+1:0] wide;
    logic [AW+1:0] amt;
    case (amode_e'(mode))
      AM_HORZ: amt = (AW+2)'(1);
      AM_VERT: amt = (AW+2)'(STRIDE % DEPTH);
      default: amt = '0;
    endcase
    if (up) wide = {2'b00, a} + amt;
    else    wide = {2'b00, a} + (AW+2)'(DEPTH) - amt;
    if (wide >= (AW+2)'(DEPTH)) wide = wide - (AW+2)'(DEPTH);
    return wide[AW-1:0];
  endfunction

  assign addr_nxt = step_addr(addr, inc, am);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= addr_nxt;
  end
endmodule

// File: rtl/gram_rd_latch.sv
module gram_rd_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill,
  input  logic [DW-1:0] fill_data,
  input  logic          invalidate,
  output logic [DW-1:0] word,
  output logic          valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '0;
      valid <= 1'b0;
    end else begin
      if (fill) word <= fill_data;
      if (invalidate)  valid <= 1'b0;
      else if (fill)   valid <= 1'b1;
    end
  end
endmodule

// File: rtl/gram_logic_op.sv
module gram_logic_op #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] bus_w,
  input  logic [DW-1:0] lat_w,
  input  logic [1:0]    mode,
  output logic [DW-1:0] result
);
  import gram_pkg::*;

  function automatic logic combine_bit(input logic b, input logic l,
                                       input logic [1:0] m);
    case (lop_e'(m))
      LOP_AND: return b & l;
      LOP_OR:  return b | l;
      LOP_XOR: return b ^ l;
      default: return b;
    endcase
  endfunction

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign result[i] = combine_bit(bus_w[i], lat_w[i], mode);
  end
endmodule

// File: rtl/gram_array.sv
module gram_array #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/gram_host_port.sv
module gram_host_port #(
  parameter int DW     = 16,
  parameter int DEPTH  = 1024,
  parameter int STRIDE = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_valid,
  input  logic          rs,
  input  logic          rw,
  input  logic [DW-1:0] din,
  input  logic          inc,
  input  logic [1:0]    am,
  input  logic [1:0]    lop,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  // decoded bus events, named for the checker
  logic ev_addr_set, ev_rd, ev_wr, ev_dummy, ev_data_rd, ev_step;
  logic [AW-1:0] addr, addr_nxt;
  logic [DW-1:0] lat_word, ram_cur, ram_nxt, wr_word, fill_word;
  logic          lat_valid;

  assign ev_addr_set = cyc_valid & ~rs & ~rw;
  assign ev_rd       = cyc_valid &  rs &  rw;
  assign ev_wr       = cyc_valid &  rs & ~rw;
  assign ev_dummy    = ev_rd & ~lat_valid;
  assign ev_data_rd  = ev_rd &  lat_valid;
  assign ev_step     = ev_data_rd | ev_wr;

  gram_addr_ctr #(.DEPTH(DEPTH), .STRIDE(STRIDE)) u_actr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_addr_set),
    .load_val (din[AW-1:0]),
    .step     (ev_step),
    .inc      (inc),
    .am       (am),
    .addr     (addr),
    .addr_nxt (addr_nxt)
  );

  gram_array #(.DW(DW), .DEPTH(DEPTH)) u_ram (
    .clk     (clk),
    .we      (ev_wr),
    .waddr   (addr),
    .wdata   (wr_word),
    .raddr_a (addr),
    .rdata_a (ram_cur),
    .raddr_b (addr_nxt),
    .rdata_b (ram_nxt)
  );

  // dummy read latches the current word; data read prefetches the next one
  assign fill_word = ev_dummy ? ram_cur : ram_nxt;

  gram_rd_latch #(.DW(DW)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill       (ev_rd),
    .fill_data  (fill_word),
    .invalidate (ev_addr_set | ev_wr),
    .word       (lat_word),
    .valid      (lat_valid)
  );

  gram_logic_op #(.DW(DW)) u_lop (
    .bus_w  (din),
    .lat_w  (lat_word),
    .mode   (lop),
    .result (wr_word)
  );

  assign dout_oe = ev_rd;
  assign dout    = ev_rd ? lat_word : '0;
endmodule

// File: rtl/gram_host_port_chk.sv
module gram_host_port_chk #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_valid,
  input logic          rs,
  input logic          rw,
  input logic [DW-1:0] din,
  input logic [DW-1:0] dout,
  input logic          dout_oe,
  input logic          ev_addr_set,
  input logic          ev_wr,
  input logic          ev_dummy,
  input logic          ev_data_rd,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] lat_word,
  input logic          lat_valid
);
  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);

  a_r3_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_set |=> addr == $past(din[AW-1:0]) && !lat_valid);

  a_r4_dummy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dummy |=> lat_valid && addr == $past(addr));

  a_r5_data_rd_drives: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_rd |-> dout_oe && dout == lat_word);

  a_r7_wr_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> !lat_valid);

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_valid || (!rs && rw)) |=> $stable(addr) && $stable(lat_word) && $stable(lat_valid));
endmodule

bind gram_host_port gram_host_port_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cyc_valid   (cyc_valid),
  .rs          (rs),
  .rw          (rw),
  .din         (din),
  .dout        (dout),
  .dout_oe     (dout_oe),
  .ev_addr_set (ev_addr_set),
  .ev_wr       (ev_wr),
  .ev_dummy    (ev_dummy),
  .ev_data_rd  (ev_data_rd),
  .addr        (addr),
  .lat_word    (lat_word),
  .lat_valid   (lat_valid)
);

// File: tb/gram_host_port_tb.sv
module gram_host_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic        rs = 1'b0, rw = 1'b0, inc = 1'b1;
  logic [15:0] din = '0;
  logic [1:0]  am = '0, lop = '0;
  logic [15:0] dout;
  logic        dout_oe;

  gram_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .rs(rs), .rw(rw),
    .din(din), .inc(inc), .am(am), .lop(lop), .dout(dout), .dout_oe(dout_oe)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] smem [1024];
  logic [15:0] s_dout;
  logic        s_oe;

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 40503) ^ 16'hA5C3;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic r_s, input logic r_w, input logic [15:0] d,
                     input logic up, input logic [1:0] m, input logic [1:0] op);
    @(negedge clk);
    cyc_valid = 1'b1; rs = r_s; rw = r_w; din = d; inc = up; am = m; lop = op;
    #2;
    s_dout = dout; s_oe = dout_oe;
  endtask

  task automatic idle();
    @(negedge clk);
    cyc_valid = 1'b0;
    #2;
    s_dout = dout; s_oe = dout_oe;
  endtask

  task automatic set_a(input int a, input logic up, input logic [1:0] m);
    acc(1'b0, 1'b0, 16'(a), up, m, 2'b00);
  endtask

  task automatic rd();
    acc(1'b1, 1'b1, 16'h0, 1'b1, 2'b00, 2'b00);
  endtask

  task automatic wr(input logic [15:0] d, input logic [1:0] op);
    acc(1'b1, 1'b0, d, 1'b1, 2'b00, op);
  endtask

  typedef struct packed {
    logic        chk;
    logic        rs;
    logic        rw;
    logic        inc;
    logic [1:0]  am;
    logic [15:0] din;
    logic [9:0]  ea;
    logic [3:0]  req;
  } vec_t;

  // read streams over a RAM holding pat(a) at every address a
  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b1,2'b00,16'd5,   10'd0,   4'd3},  // R3 set 5
    '{1'b0,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd0,   4'd4},  // R4 dummy
    '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd5,   4'd5},  // R5 word 5
    '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd6,   4'd5},  // R5
    '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd7,   4'd5},  // R5
    '{1'b0,1'b0,1'b0,1'b1,2'b01,16'd100, 10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd100, 4'd6},  // R6 vertical up
    '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd132, 4'd6},
    '{1'b0,1'b0,1'b0,1'b0,2'b00,16'd10,  10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b0,2'b00,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b0,2'b00,16'd0,   10'd10,  4'd6},  // R6 horizontal down
    '{1'b1,1'b1,1'b1,1'b0,2'b00,16'd0,   10'd9,   4'd6},
    '{1'b0,1'b0,1'b0,1'b1,2'b00,16'd1023,10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd1023,4'd11},
    '{1'b1,1'b1,1'b1,1'b1,2'b00,16'd0,   10'd0,   4'd11}, // R11 wrap up
    '{1'b0,1'b0,1'b0,1'b0,2'b01,16'd3,   10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b0,2'b01,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd0,   10'd3,   4'd11},
    '{1'b1,1'b1,1'b1,1'b0,2'b01,16'd0,   10'd995, 4'd11}, // R11 vertical wrap down
    '{1'b0,1'b0,1'b0,1'b1,2'b10,16'd50,  10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b1,2'b10,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b1,2'b10,16'd0,   10'd50,  4'd6},
    '{1'b1,1'b1,1'b1,1'b1,2'b10,16'd0,   10'd50,  4'd6},  // R6 hold
    '{1'b0,1'b0,1'b0,1'b0,2'b11,16'd60,  10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b0,2'b11,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b0,2'b11,16'd0,   10'd60,  4'd6},
    '{1'b1,1'b1,1'b1,1'b0,2'b11,16'd0,   10'd60,  4'd6},  // R6 hold
    '{1'b0,1'b0,1'b0,1'b1,2'b01,16'd1000,10'd0,   4'd3},
    '{1'b0,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd0,   4'd4},
    '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd1000,4'd11},
    '{1'b1,1'b1,1'b1,1'b1,2'b01,16'd0,   10'd8,   4'd11}  // R11 vertical wrap up
  };

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 oe after reset", 16'(dout_oe), 16'h0);
    chk("R1 dout after reset", dout, 16'h0);
    @(negedge clk) rst_n = 1'b1;

    // fill RAM: address 0, horizontal up, pass writes (R7)
    set_a(0, 1'b1, 2'b00);
    for (int a = 0; a < 1024; a++) begin
      wr(pat(a), 2'b00);
      smem[a] = pat(a);
    end

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].rs, VEC[i].rw, VEC[i].din, VEC[i].inc, VEC[i].am, 2'b00);
      if (VEC[i].chk) begin
        n_cmp++;
        if (s_dout !== smem[VEC[i].ea] || s_oe !== 1'b1) begin
          n_bad++;
          $display("FAIL R%0d vec %0d actual=%h expected=%h", VEC[i].req, i,
                   s_dout, smem[VEC[i].ea]);
        end
      end
    end

    // R2 and R10: ignored cycle types
    set_a(20, 1'b1, 2'b00); rd(); rd();
    chk("R5 word 20", s_dout, smem[20]);
    acc(1'b0, 1'b1, 16'hFFFF, 1'b1, 2'b00, 2'b00);
    chk("R2 oe low on rs0 read", 16'(s_oe), 16'h0);
    chk("R2 dout zero on rs0 read", s_dout, 16'h0);
    idle();
    chk("R2 dout zero when idle", s_dout, 16'h0);
    rd();
    chk("R10 stream continues at 21", s_dout, smem[21]);

    // R3: new address set forces a dummy
    set_a(30, 1'b1, 2'b00); rd(); rd();
    set_a(40, 1'b1, 2'b00); rd(); rd();
    chk("R3 fresh dummy after set", s_dout, smem[40]);

    // R7: pass writes and latch invalidation
    set_a(300, 1'b1, 2'b00);
    wr(16'hBEEF, 2'b00); smem[300] = 16'hBEEF;
    wr(16'h1234, 2'b00); smem[301] = 16'h1234;
    set_a(300, 1'b1, 2'b00); rd(); rd();
    chk("R7 write 300", s_dout, 16'hBEEF);
    rd();
    chk("R7 write 301", s_dout, 16'h1234);
    set_a(400, 1'b1, 2'b00); rd(); rd();
    wr(16'hCAFE, 2'b00); smem[401] = 16'hCAFE;
    rd(); rd();
    chk("R7 write clears latch", s_dout, smem[402]);

    // R8 / R9: read-modify-write with one dummy read
    set_a(200, 1'b1, 2'b00); rd(); wr(16'h0FF0, 2'b01);
    smem[200] = smem[200] & 16'h0FF0;
    set_a(210, 1'b1, 2'b00); rd(); wr(16'h8001, 2'b10);
    smem[210] = smem[210] | 16'h8001;
    set_a(220, 1'b1, 2'b00); rd(); wr(16'hFFFF, 2'b11);
    smem[220] = smem[220] ^ 16'hFFFF;
    set_a(200, 1'b1, 2'b00); rd(); rd();
    chk("R8 AND / R9 rmw", s_dout, smem[200]);
    set_a(210, 1'b1, 2'b00); rd(); rd();
    chk("R8 OR", s_dout, smem[210]);
    set_a(220, 1'b1, 2'b00); rd(); rd();
    chk("R8 XOR", s_dout, smem[220]);
    rd();
    chk("R9 untouched neighbour", s_dout, smem[221]);

    // R1: reset mid-run returns address to 0 and forces a dummy
    set_a(500, 1'b1, 2'b00); rd();
    idle();
    @(negedge clk) rst_n = 1'b0;
    #2;
    chk("R1 oe during reset", 16'(dout_oe), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    rd(); rd();
    chk("R1 address 0 after reset", s_dout, smem[0]);
    idle();

    summary();
  end
endmodule